// File: doc/BRIEF.md
# Bus Load Performance Counter

This block sits next to a bus port and measures how busy that port is. It has one cycle counter and four event counters. Each event counter can be set to count read-data beats, write-data beats or both. Software divides an event count by the cycle count to get a load ratio. The beat inputs are single-cycle pulses, and the block has no knowledge of the bus protocol.

Software controls the block through a 32-bit word-addressed register port. Each counter has an enable bit. These bits are turned on through a write-one-to-set register and turned off through a write-one-to-clear register. A global control register holds a run bit and two self-clearing bits that zero the counters. To take a measurement, software clears the run bit and then reads the frozen counter values. Event counter 3 is wider than the others, so its value is read through a low register and a high register.

Register map (byte addresses):

| Address | Register |
|---|---|
| 0x00 | control |
| 0x04 | enable set |
| 0x08 | enable clear |
| 0x10 to 0x1C | select registers for event counters 0 to 3 |
| 0x20 | cycle counter |
| 0x24 to 0x30 | event counters 0 to 3 (counter 3 low word at 0x30) |
| 0x34 | counter 3 high bits |

Top module: `perf_mon`

## Requirements
- R1: After reset, all counters are zero, all enable bits are zero, the run bit is zero and every select register is zero.
- R2: Writing a 1 to a bit of the enable-set register (0x04) turns that enable on. Writing a 1 to the same bit of the enable-clear register (0x08) turns it off. Writing a 0 changes nothing. Bits 3:0 enable event counters 0 to 3 and bit 31 enables the cycle counter. Both registers read back the current enable mask.
- R3: Control bit 0 is the run bit. While the run bit reads 0, no counter changes value, whatever beats arrive.
- R4: Select register bits 1:0 choose what an event counter counts: 0 counts nothing, 1 counts read beats, 2 counts write beats and 3 counts both. With code 3, a read beat and a write beat in the same cycle add 2.
- R5: The cycle counter (0x20) advances by 1 on every clock edge at which the run bit and enable bit 31 are both set.
- R6: Writing 1 to control bit 1 zeroes all event counters, and writing 1 to control bit 2 zeroes the cycle counter. The counter is already zero in the cycle after the write. Both bits always read as 0.
- R7: Event counter 3 is CNT_W+HI_W bits wide (40 bits by default). Its low CNT_W bits read at 0x30, and its upper HI_W bits read at 0x34 in bits HI_W-1:0.
- R8: The cycle counter and event counters 0 to 2 are CNT_W bits wide and wrap to zero after their maximum value. When the low part of counter 3 overflows, the carry moves into its high part.
- R9: A read of any unmapped address returns zero. A write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address; bits 1:0 are ignored |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| rd_beat_i | input | 1 | Pulse for one read-data beat |
| wr_beat_i | input | 1 | Pulse for one write-data beat |

## Verification
The assertions check on every cycle the following behaviours:
- enable bits respond to writes on the set and clear registers;
- a counter is zero one cycle after a reset bit is written;
- a counter never steps by more than two;
- a counter holds its value whenever it gets no step or the run bit is low;
- unmapped reads return zero.

Only the bench scenarios can show that the exact counts match the select codes for mixed beat patterns and that a cleared enable or a zero select code stops one counter while the others keep counting. They also show the low-to-high carry of the wide counter and the wrap of the narrow ones, using a second instance with narrow counters.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
  localparam int REG_W      = 32;
  localparam int NUM_EVT    = 4;
  localparam int CYC_EN_BIT = 31;

  // control register bits
  localparam int RUN_BIT     = 0;
  localparam int EVT_RST_BIT = 1;
  localparam int CYC_RST_BIT = 2;

  // word indices (byte address >> 2)
  localparam int IX_CTRL   = 0;
  localparam int IX_EN_SET = 1;
  localparam int IX_EN_CLR = 2;
  localparam int IX_SEL0   = 4;
  localparam int IX_CYC    = 8;
  localparam int IX_CNT0   = 9;
  localparam int IX_CNT_HI = IX_CNT0 + NUM_EVT;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_RD   = 2'd1,
    EV_WR   = 2'd2,
    EV_RW   = 2'd3
  } evt_sel_e;
endpackage

// File: rtl/perf_mon_ctrl.sv
module perf_mon_ctrl
  import perf_mon_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [IDX_W-1:0]         widx_i,
  input  logic [REG_W-1:0]         wdata_i,
  output logic                     run_o,
  output logic [NUM_EVT:0]         en_o,     // bit NUM_EVT = cycle counter
  output logic [NUM_EVT-1:0][1:0]  sel_o,
  output logic                     evt_clr_o,
  output logic                     cyc_clr_o
);
  logic              wr_ctrl, wr_set, wr_clr;
  logic [NUM_EVT:0]  wbits;

  assign wr_ctrl = we_i && (widx_i == IDX_W'(IX_CTRL));
  assign wr_set  = we_i && (widx_i == IDX_W'(IX_EN_SET));
  assign wr_clr  = we_i && (widx_i == IDX_W'(IX_EN_CLR));
  assign wbits   = {wdata_i[CYC_EN_BIT], wdata_i[NUM_EVT-1:0]};

  assign evt_clr_o = wr_ctrl && wdata_i[EVT_RST_BIT];
  assign cyc_clr_o = wr_ctrl && wdata_i[CYC_RST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0;
      en_o  <= '0;
    end else begin
      if (wr_ctrl) run_o <= wdata_i[RUN_BIT];
      if (wr_set)  en_o  <= en_o | wbits;
      else if (wr_clr) en_o <= en_o & ~wbits;
    end
  end

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_sel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sel_o[g] <= EV_NONE;
      else if (we_i && (widx_i == IDX_W'(IX_SEL0 + g))) sel_o[g] <= wdata_i[1:0];
    end
  end

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((en_o & $past(wbits)) == $past(wbits)));
  p_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((en_o & $past(wbits)) == '0));
  p_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_set || wr_clr) |=> $stable(en_o));
endmodule

// File: rtl/perf_mon_cnt.sv
module perf_mon_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [1:0]   step_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;     // clear wins over counting
    else             cnt_o <= cnt_o + W'(step_i);
  end

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && step_i == 2'd0) |=> $stable(cnt_o));
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((cnt_o - $past(cnt_o)) <= W'(2)));
endmodule

// File: rtl/perf_mon.sv
module perf_mon
  import perf_mon_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int HI_W   = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              rd_beat_i,
  input  logic              wr_beat_i
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int WIDE_W = CNT_W + HI_W;

  logic [IDX_W-1:0]              widx;
  logic                          run, evt_clr, cyc_clr;
  logic [NUM_EVT:0]              en;
  logic [NUM_EVT-1:0][1:0]       sel;
  logic [NUM_EVT-1:0][REG_W-1:0] cnt_lo;
  logic [REG_W-1:0]              cnt_hi;
  logic [CNT_W-1:0]              cyc_cnt;
  logic [REG_W-1:0]              en_word;
  logic                          mapped;

  assign widx = reg_addr_i[ADDR_W-1:2];

  perf_mon_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .widx_i(widx), .wdata_i(reg_wdata_i),
    .run_o(run), .en_o(en), .sel_o(sel),
    .evt_clr_o(evt_clr), .cyc_clr_o(cyc_clr)
  );

  perf_mon_cnt #(.W(CNT_W)) u_cyc (
    .clk_i, .rst_ni, .clr_i(cyc_clr),
    .step_i({1'b0, run & en[NUM_EVT]}), .cnt_o(cyc_cnt)
  );

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    localparam int W = (g == NUM_EVT - 1) ? WIDE_W : CNT_W;
    logic [W-1:0] cnt;
    logic [1:0]   step;

    assign step = (run && en[g]) ?
                  (2'(sel[g][0] & rd_beat_i) + 2'(sel[g][1] & wr_beat_i)) : 2'd0;

    perf_mon_cnt #(.W(W)) u_cnt (
      .clk_i, .rst_ni, .clr_i(evt_clr), .step_i(step), .cnt_o(cnt)
    );

    assign cnt_lo[g] = REG_W'(cnt[CNT_W-1:0]);
    if (g == NUM_EVT - 1) begin : g_wide
      assign cnt_hi = REG_W'(cnt[WIDE_W-1:CNT_W]);
    end
  end

  always_comb begin
    en_word = '0;
    en_word[NUM_EVT-1:0] = en[NUM_EVT-1:0];
    en_word[CYC_EN_BIT]  = en[NUM_EVT];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (widx == IDX_W'(IX_CTRL))   reg_rdata_o[RUN_BIT] = run;
    if (widx == IDX_W'(IX_EN_SET) || widx == IDX_W'(IX_EN_CLR)) reg_rdata_o = en_word;
    if (widx == IDX_W'(IX_CYC))    reg_rdata_o = REG_W'(cyc_cnt);
    if (widx == IDX_W'(IX_CNT_HI)) reg_rdata_o = cnt_hi;
    for (int g = 0; g < NUM_EVT; g++) begin
      if (widx == IDX_W'(IX_SEL0 + g)) reg_rdata_o = REG_W'(sel[g]);
      if (widx == IDX_W'(IX_CNT0 + g)) reg_rdata_o = cnt_lo[g];
    end
  end

  // independent decode of the populated map for the R9 check
  assign mapped = (widx <= IDX_W'(IX_EN_CLR)) ||
                  (widx >= IDX_W'(IX_SEL0) && widx <= IDX_W'(IX_CNT_HI));

  p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> (reg_rdata_o == '0));
  p_stopped_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !cyc_clr) |=> $stable(cyc_cnt));
  p_cyc_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && en[NUM_EVT] && !cyc_clr) |=> (cyc_cnt == $past(cyc_cnt) + CNT_W'(1)));
endmodule

// File: tb/perf_mon_tb_top.sv
`timescale 1ns/1ps
module perf_mon_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_w;
  logic        rd = 1'b0, wr = 1'b0;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  perf_mon dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rd_beat_i(rd), .wr_beat_i(wr)
  );

  // narrow instance so wrap and carry are reachable in a short run
  perf_mon #(.CNT_W(6), .HI_W(8), .ADDR_W(8)) dut_w_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_w), .rd_beat_i(rd), .wr_beat_i(wr)
  );

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input logic r, input logic w, input int n);
    for (int i = 0; i < n; i++) begin
      rd = r; wr = w;
      @(negedge clk);
    end
    rd = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp,
                        input string req, input bit narrow = 1'b0);
    logic [31:0] got;
    addr = a;
    #1;
    got = narrow ? rdata_w : rdata;
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%02h actual=%08h expected=%08h", req, a, got, exp);
    end
    @(negedge clk);
  endtask

  // {op[1:0], addr[7:0], data[31:0], rd, wr, req[3:0]}; op 0=write 1=read-check 2=beats
  localparam int NV = 33;
  localparam logic [47:0] VECS [NV] = '{
    {2'd0, 8'h04, 32'h8000000F, 1'b0, 1'b0, 4'd2},  // R2 enable all
    {2'd0, 8'h10, 32'h1,        1'b0, 1'b0, 4'd4},  // R4 sel0 read
    {2'd0, 8'h14, 32'h2,        1'b0, 1'b0, 4'd4},  // sel1 write
    {2'd0, 8'h18, 32'h3,        1'b0, 1'b0, 4'd4},  // sel2 both
    {2'd0, 8'h1C, 32'h3,        1'b0, 1'b0, 4'd4},  // sel3 both
    {2'd0, 8'h00, 32'h7,        1'b0, 1'b0, 4'd6},  // R6 clear + run
    {2'd2, 8'h00, 32'h0,        1'b1, 1'b0, 4'd4},
    {2'd2, 8'h00, 32'h0,        1'b1, 1'b0, 4'd4},
    {2'd2, 8'h00, 32'h0,        1'b1, 1'b0, 4'd4},
    {2'd2, 8'h00, 32'h0,        1'b0, 1'b1, 4'd4},
    {2'd2, 8'h00, 32'h0,        1'b0, 1'b1, 4'd4},
    {2'd2, 8'h00, 32'h0,        1'b1, 1'b1, 4'd4},
    {2'd0, 8'h00, 32'h0,        1'b0, 1'b0, 4'd3},  // R3 stop
    {2'd2, 8'h00, 32'h0,        1'b1, 1'b1, 4'd3},
    {2'd2, 8'h00, 32'h0,        1'b1, 1'b1, 4'd3},
    {2'd1, 8'h20, 32'd7,        1'b0, 1'b0, 4'd5},  // R5
    {2'd1, 8'h24, 32'd4,        1'b0, 1'b0, 4'd4},
    {2'd1, 8'h28, 32'd3,        1'b0, 1'b0, 4'd4},
    {2'd1, 8'h2C, 32'd7,        1'b0, 1'b0, 4'd4},
    {2'd1, 8'h30, 32'd7,        1'b0, 1'b0, 4'd7},  // R7
    {2'd1, 8'h34, 32'd0,        1'b0, 1'b0, 4'd7},
    {2'd1, 8'h00, 32'd0,        1'b0, 1'b0, 4'd6},
    {2'd1, 8'h04, 32'h8000000F, 1'b0, 1'b0, 4'd2},
    {2'd1, 8'h08, 32'h8000000F, 1'b0, 1'b0, 4'd2},
    {2'd0, 8'h08, 32'h1,        1'b0, 1'b0, 4'd2},
    {2'd1, 8'h04, 32'h8000000E, 1'b0, 1'b0, 4'd2},
    {2'd0, 8'h04, 32'h0,        1'b0, 1'b0, 4'd2},
    {2'd1, 8'h08, 32'h8000000E, 1'b0, 1'b0, 4'd2},
    {2'd1, 8'h3C, 32'h0,        1'b0, 1'b0, 4'd9},  // R9
    {2'd0, 8'h3C, 32'hFFFFFFFF, 1'b0, 1'b0, 4'd9},
    {2'd1, 8'h10, 32'h1,        1'b0, 1'b0, 4'd9},
    {2'd1, 8'h04, 32'h8000000E, 1'b0, 1'b0, 4'd9},
    {2'd1, 8'h2C, 32'd7,        1'b0, 1'b0, 4'd3}   // still frozen
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk(8'h00, 32'h0, "R1");
    rd_chk(8'h04, 32'h0, "R1");
    rd_chk(8'h10, 32'h0, "R1");
    rd_chk(8'h20, 32'h0, "R1");
    rd_chk(8'h24, 32'h0, "R1");
    rd_chk(8'h34, 32'h0, "R1");

    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      v = VECS[i];
      case (v[47:46])
        2'd0: wr_reg(v[45:38], v[37:6]);
        2'd1: rd_chk(v[45:38], v[37:6], $sformatf("R%0d", v[3:0]));
        default: idle(v[5], v[4], 1);
      endcase
    end

    // R6 event reset only, cycle counter untouched
    wr_reg(8'h00, 32'h2);
    rd_chk(8'h2C, 32'd0, "R6");
    rd_chk(8'h20, 32'd7, "R6");
    rd_chk(8'h00, 32'd0, "R6");
    wr_reg(8'h00, 32'h4);
    rd_chk(8'h20, 32'd0, "R6");

    // R2 disabled counter, R4 select none, R3 run readback
    wr_reg(8'h14, 32'h0);
    wr_reg(8'h00, 32'h1);
    rd_chk(8'h00, 32'd1, "R3");
    idle(1'b1, 1'b1, 2);
    idle(1'b1, 1'b0, 1);
    wr_reg(8'h00, 32'h0);
    rd_chk(8'h20, 32'd5, "R5");
    rd_chk(8'h24, 32'd0, "R2");
    rd_chk(8'h28, 32'd0, "R4");
    rd_chk(8'h2C, 32'd5, "R4");
    rd_chk(8'h30, 32'd5, "R7");

    // R8 wrap and carry on the narrow instance
    wr_reg(8'h04, 32'h8000000F);
    wr_reg(8'h1C, 32'h1);
    wr_reg(8'h00, 32'h7);
    idle(1'b1, 1'b0, 70);
    wr_reg(8'h00, 32'h0);
    rd_chk(8'h24, 32'd70, "R8");
    rd_chk(8'h20, 32'd71, "R8");
    rd_chk(8'h24, 32'd6,  "R8", 1'b1);
    rd_chk(8'h20, 32'd7,  "R8", 1'b1);
    rd_chk(8'h2C, 32'd6,  "R8", 1'b1);
    rd_chk(8'h30, 32'd6,  "R7", 1'b1);
    rd_chk(8'h34, 32'd1,  "R7", 1'b1);
    rd_chk(8'h34, 32'd0,  "R7");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule